// File: doc/BRIEF.md
# Three-Line Serial Audio Receiver

This block takes PCM audio from a synchronous serial port with one word clock, one bit clock and three data lines, and turns it into six parallel 24-bit channel words. Each data line carries one stereo pair per frame. The left word comes first and the right word follows. The receiver sees both clocks as plain inputs that are synchronous to, and slower than, its system clock. It finds bit-clock rising edges in the system-clock domain and samples every data line at those edges.

Three framing formats can be selected on a 3-bit input. In right-aligned mode the word ends on the bit before a word-clock change. In I2S mode the left half is word-clock low and the word starts one bit late. In left-aligned mode the word starts on the first bit of the half. Frames of 48 or 64 bit clocks per sample are accepted without any setting, because positions are counted from each word-clock change. The format is treated as static: change it only while the block is held in reset.

When the right half of a frame ends, all six output words are loaded together and a one-cycle valid strobe fires. The outputs then hold until the next frame completes.

Top module: `audio_serial_rx`

## Requirements
- R1: Data and word-clock levels are taken only at a rising edge of the bit clock. Data that changes while the bit clock is steady, low or high, has no effect on the output words.
- R2: Output words change only in the system cycle that follows a bit-clock rising edge on which the word clock has changed level. All six words change in the same cycle.
- R3: Frames of 48 and 64 bit clocks per sample both decode correctly, with no configuration.
- R4: Output index 2k carries the left word of data line k, and index 2k+1 carries its right word (k = 0, 1, 2).
- R5: Samples are 24-bit two's complement, sent MSB first. Extreme codes such as 800000h and 7FFFFFh pass through unchanged.
- R6: Format code 000 selects right-aligned framing. The left half is word clock high, and the word is the last 24 bits before the word-clock change. Any leading padding is discarded.
- R7: Format code 001 selects I2S framing. The left half is word clock low, and the MSB comes on the second bit of the half. At 48 bits per frame the LSB falls on the first bit of the following half.
- R8: Format code 010 selects left-aligned framing. The left half is word clock high, and the MSB comes on the first bit of the half. Bits after the 24th are ignored.
- R9: Format codes 011 to 111 behave exactly like code 000.
- R10: After reset all words are zero and valid is low. No frame is reported until a complete left half has been received, beginning at a word-clock change seen after reset.
- R11: The valid strobe lasts one system cycle per frame. Between strobes the output words hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock, synchronous to clk |
| wclk | input | 1 | Word clock, toggles at the sample rate |
| sdata | input | NLINES | Serial data lines, one stereo pair each |
| fmt | input | 3 | Framing format code |
| ch_word | output | 2*NLINES x WIDTH | Channel words, index 2k left / 2k+1 right of line k |
| smp_valid | output | 1 | One-cycle strobe when all channel words update |

## Verification
The hardest case to reach is the I2S frame at 48 bits per sample. There the LSB of the right word arrives on the same bit-clock edge that shows the word-clock change. The word must therefore be completed from that edge's own data bit while the next half is already starting. The bench builds its serial stream from whole frames placed in a bit buffer, so at 48 bits per frame the I2S words spill into the next half. Padding bits before right-aligned words and after left-aligned words are filled with random values. In a separate phase, the data lines are flipped while the bit clock is steady, which shows whether any bit is taken away from the rising edge.

// File: rtl/audio_rx_pkg.sv
// Package: shared format type and code decode for the serial audio receiver.
package audio_rx_pkg;

    // Decoded framing formats.
    typedef enum logic [1:0] {
        FMT_RIGHT = 2'd0,
        FMT_I2S   = 2'd1,
        FMT_LEFT  = 2'd2
    } fmt_e;

    // Maps the 3-bit format code to a framing format; unused codes fall back to right-aligned.
    function automatic fmt_e fmt_decode(input logic [2:0] code);
        case (code)
            3'b001:  return FMT_I2S;
            3'b010:  return FMT_LEFT;
            default: return FMT_RIGHT;
        endcase
    endfunction

    // Word-clock level that marks the left half in a given format.
    function automatic logic left_level(input fmt_e f);
        return (f != FMT_I2S);
    endfunction

endpackage

// File: rtl/audio_rx_bitclk.sv
// Bit-clock tracker: finds bit-clock rising edges in the system-clock domain,
// detects word-clock changes at those edges and counts the bit position within
// the current half-frame. Assumes bclk and wclk are synchronous to clk and that
// bclk stays high and low for at least one clk cycle each.
module audio_rx_bitclk #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk,
    input  logic          wclk,
    output logic          bit_stb,
    output logic          edge_stb,
    output logic          synced,
    output logic          prev_level,
    output logic [CW-1:0] idx,
    output logic [CW-1:0] last_idx
);
    localparam logic [CW-1:0] POS_MAX = '1;

    logic          bclk_q;
    logic          started;
    logic          synced_q;
    logic          wclk_q;
    logic [CW-1:0] pos;

    // Strobes and index of the bit being sampled this cycle.
    always_comb begin
        bit_stb  = bclk & ~bclk_q;
        edge_stb = bit_stb & started & (wclk != wclk_q);
        if (edge_stb)
            idx = '0;
        else if (pos == POS_MAX)
            idx = POS_MAX;
        else
            idx = pos + 1'b1;
    end

    assign synced     = synced_q;
    assign prev_level = wclk_q;
    assign last_idx   = pos;

    // Tracks bit-clock history, word-clock level, half-frame position and sync state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q   <= 1'b0;
            started  <= 1'b0;
            synced_q <= 1'b0;
            wclk_q   <= 1'b0;
            pos      <= '0;
        end else begin
            bclk_q <= bclk;
            if (bit_stb) begin
                started <= 1'b1;
                wclk_q  <= wclk;
                pos     <= started ? idx : '0;
                if (edge_stb)
                    synced_q <= 1'b1;
            end
        end
    end

    // The half-frame position only moves on a bit-clock rising edge.
    assert_pos_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(pos));

    // Word-clock level is only re-sampled on a bit-clock rising edge.
    assert_level_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(prev_level));

endmodule

// File: rtl/audio_rx_lane.sv
// One data-line lane: shifts the bits that belong to the word of the current
// half and presents the finished word at each word-clock change. I2S words may
// take their LSB from the edge bit itself. Holds the left word until the frame's
// right word is complete. Assumes the format stays constant outside reset.
module audio_rx_lane
    import audio_rx_pkg::*;
#(
    parameter int WIDTH = 24,
    parameter int CW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             edge_stb,
    input  logic             left_end,
    input  logic             din,
    input  fmt_e             mode,
    input  logic [CW-1:0]    idx,
    input  logic [CW-1:0]    last_idx,
    output logic [WIDTH-1:0] hold_left,
    output logic [WIDTH-1:0] fin_word
);
    localparam logic [CW-1:0] W_C  = CW'(WIDTH);
    localparam logic [CW-1:0] W_M1 = CW'(WIDTH - 1);

    logic [WIDTH-1:0] acc;
    logic             take;
    logic             spill;

    // Decides whether the current bit belongs to a word, and completes the word at an edge.
    always_comb begin
        case (mode)
            FMT_LEFT: take = (idx < W_C);
            FMT_I2S:  take = (idx != '0) && (idx <= W_C);
            default:  take = 1'b1;
        endcase
        spill    = (mode == FMT_I2S) && edge_stb && (last_idx == W_M1);
        fin_word = spill ? {acc[WIDTH-2:0], din} : acc;
    end

    // Shifts accepted bits in MSB first and stores the finished left word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            hold_left <= '0;
        end else begin
            if (bit_stb && take)
                acc <= {acc[WIDTH-2:0], din};
            if (left_end)
                hold_left <= fin_word;
        end
    end

    // The stored left word only changes at a word-clock change.
    assert_left_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !edge_stb) |=> $stable(hold_left));

    // Without a bit-clock edge the shift register stays put.
    assert_acc_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(acc));

endmodule

// File: rtl/audio_serial_rx.sv
// Three-line serial audio receiver top: one shared bit-clock tracker, one lane
// per data line and the frame logic that loads all channel words together once
// a right half has ended after a complete left half.
// Assumes bclk/wclk are synchronous to clk and the format is static outside reset.
module audio_serial_rx
    import audio_rx_pkg::*;
#(
    parameter int NLINES = 3,
    parameter int WIDTH  = 24
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bclk,
    input  logic                               wclk,
    input  logic [NLINES-1:0]                  sdata,
    input  logic [2:0]                         fmt,
    output logic [2*NLINES-1:0][WIDTH-1:0]     ch_word,
    output logic                               smp_valid
);
    localparam int CW = $clog2(2 * WIDTH) + 1;

    fmt_e             mode;
    logic             bit_stb;
    logic             edge_stb;
    logic             synced;
    logic             prev_level;
    logic [CW-1:0]    idx;
    logic [CW-1:0]    last_idx;
    logic             old_left;
    logic             left_end;
    logic             right_end;
    logic             have_left;
    logic [WIDTH-1:0] hold_w [NLINES];
    logic [WIDTH-1:0] fin_w  [NLINES];

    assign mode = fmt_decode(fmt);

    audio_rx_bitclk #(.CW(CW)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .wclk       (wclk),
        .bit_stb    (bit_stb),
        .edge_stb   (edge_stb),
        .synced     (synced),
        .prev_level (prev_level),
        .idx        (idx),
        .last_idx   (last_idx)
    );

    // Classifies the half that just ended as left or right.
    always_comb begin
        old_left  = (prev_level == left_level(mode));
        left_end  = edge_stb & synced & old_left;
        right_end = edge_stb & synced & ~old_left;
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_lane
        audio_rx_lane #(.WIDTH(WIDTH), .CW(CW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .bit_stb   (bit_stb),
            .edge_stb  (edge_stb),
            .left_end  (left_end),
            .din       (sdata[g]),
            .mode      (mode),
            .idx       (idx),
            .last_idx  (last_idx),
            .hold_left (hold_w[g]),
            .fin_word  (fin_w[g])
        );
    end

    // Loads all channel words together at the end of a complete frame and pulses valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_left <= 1'b0;
            smp_valid <= 1'b0;
            ch_word   <= '0;
        end else begin
            smp_valid <= 1'b0;
            if (left_end)
                have_left <= 1'b1;
            else if (right_end)
                have_left <= 1'b0;
            if (right_end && have_left) begin
                smp_valid <= 1'b1;
                for (int g = 0; g < NLINES; g++) begin
                    ch_word[2*g]   <= hold_w[g];
                    ch_word[2*g+1] <= fin_w[g];
                end
            end
        end
    end

    // Valid lasts exactly one cycle.
    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // Words hold between strobes.
    assert_words_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !smp_valid) |-> $stable(ch_word));

    // A frame is only reported right after a word-clock change.
    assert_valid_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(edge_stb));

    // A frame needs a completed left half received after synchronisation.
    assert_needs_left_R10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ($past(have_left) && $past(synced)));

endmodule

// File: tb/audio_serial_rx_test.sv
// Bench: builds serial streams from whole frames in a bit buffer, plays them
// with a bit clock of four system cycles and compares the outputs on every clock.
module audio_serial_rx_test;

    localparam int NL   = 3;
    localparam int W    = 24;
    localparam int NFR  = 4;
    localparam int BUFN = 1024;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   bclk = 1'b0;
    logic                   wclk = 1'b0;
    logic [NL-1:0]          sdata = '0;
    logic [2:0]             fmt = 3'b000;
    logic [2*NL-1:0][W-1:0] ch_word;
    logic                   smp_valid;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [NL-1:0]          sbuf  [BUFN];
    logic                   wbuf  [BUFN];
    bit                     lflag [BUFN];
    logic [W-1:0]           expv  [NFR][2*NL];
    logic [2*NL-1:0][W-1:0] exp_hold;
    int                     fidx;
    bit                     glitch;
    string                  tag;

    always #5 clk = ~clk;

    audio_serial_rx #(.NLINES(NL), .WIDTH(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .wclk      (wclk),
        .sdata     (sdata),
        .fmt       (fmt),
        .ch_word   (ch_word),
        .smp_valid (smp_valid)
    );

    // Compares valid and all words against the model at one negedge.
    task automatic compare(input bit ev);
        checks++;
        if (smp_valid !== ev) begin
            errors++;
            $display("FAIL R2/R11 %s valid got %0b exp %0b frame %0d", tag, smp_valid, ev, fidx);
        end
        if (ev) begin
            for (int c = 0; c < 2*NL; c++) exp_hold[c] = expv[fidx][c];
            fidx++;
        end
        for (int c = 0; c < 2*NL; c++) begin
            checks++;
            if (ch_word[c] !== exp_hold[c]) begin
                errors++;
                $display("FAIL R4/R5 %s ch%0d got %h exp %h", tag, c, ch_word[c], exp_hold[c]);
            end
        end
    endtask

    // Plays one bit over four system cycles, optionally corrupting data while bclk is steady.
    task automatic send_bit(input int i);
        @(negedge clk); compare(1'b0);
        bclk = 1'b0; wclk = wbuf[i]; sdata = glitch ? ~sbuf[i] : sbuf[i];
        @(negedge clk); compare(1'b0);
        sdata = sbuf[i];
        @(negedge clk); compare(1'b0);
        bclk = 1'b1;
        @(negedge clk); compare(lflag[i]);
        if (glitch) sdata = ~sbuf[i];
    endtask

    // Writes one 24-bit word of one line into the buffer at the format's positions.
    task automatic place(input int start, input int hl, input int md, input int ln, input logic [W-1:0] v);
        for (int b = 0; b < W; b++) begin
            int p;
            if (md == 0)      p = start + hl - W + b;
            else if (md == 1) p = start + 1 + b;
            else              p = start + b;
            sbuf[p][ln] = v[W-1-b];
        end
    endtask

    // Runs one phase: reset, build the stream for a format and ratio, play it.
    task automatic run_phase(input logic [2:0] code, input int ratio, input bit glt, input string t);
        int md, hl, lvl, len;
        tag = t; glitch = glt; fmt = code;
        md  = (code == 3'b001) ? 1 : (code == 3'b010) ? 2 : 0;
        hl  = ratio / 2;
        lvl = (md == 1) ? 0 : 1;
        len = hl + NFR*2*hl + hl;
        for (int i = 0; i < BUFN; i++) begin
            sbuf[i] = NL'($urandom); wbuf[i] = 1'b0; lflag[i] = 1'b0;
        end
        for (int k = 0; k < NFR; k++)
            for (int c = 0; c < 2*NL; c++) expv[k][c] = W'($urandom);
        expv[0][0] = 24'h800000; expv[0][1] = 24'h7FFFFF; expv[0][2] = 24'h000000;
        expv[0][3] = 24'hFFFFFF; expv[0][4] = 24'h000001; expv[0][5] = 24'hA5A5A5;
        for (int i = 0; i < len; i++) begin
            int h = i / hl;
            wbuf[i] = (h % 2 == 1) ? 1'(lvl) : 1'(1 - lvl);
        end
        for (int k = 0; k < NFR; k++) begin
            int sl = hl + k*2*hl;
            for (int j = 0; j < NL; j++) begin
                place(sl,      hl, md, j, expv[k][2*j]);
                place(sl + hl, hl, md, j, expv[k][2*j+1]);
            end
            lflag[sl + 2*hl] = 1'b1;
        end
        rst_n = 1'b0; bclk = 1'b0; sdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        exp_hold = '0; fidx = 0;
        @(negedge clk);
        checks++;
        if (smp_valid !== 1'b0 || ch_word !== '0) begin
            errors++;
            $display("FAIL R10 %s reset state valid=%0b words=%h exp 0", tag, smp_valid, ch_word);
        end
        for (int i = 0; i < len; i++) send_bit(i);
        checks++;
        if (fidx != NFR) begin
            errors++;
            $display("FAIL R2 %s frames got %0d exp %0d", tag, fidx, NFR);
        end
    endtask

    initial begin
        run_phase(3'b000, 48, 1'b0, "R6 R3 R10 right-aligned 48");
        run_phase(3'b000, 64, 1'b0, "R6 R3 right-aligned 64 padding");
        run_phase(3'b001, 48, 1'b0, "R7 R3 i2s 48 spill");
        run_phase(3'b001, 64, 1'b0, "R7 R3 i2s 64");
        run_phase(3'b010, 48, 1'b0, "R8 R3 left-aligned 48");
        run_phase(3'b010, 64, 1'b1, "R8 R1 left-aligned 64 glitch");
        run_phase(3'b101, 64, 1'b1, "R9 R1 code 101");
        run_phase(3'b111, 48, 1'b0, "R9 code 111");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule